// File: doc/BRIEF.md
# Register Rename Stage with Offset Folding

This block is the rename stage of an out-of-order core. Each architectural register maps to a pair: a physical tag and a small unsigned offset. The value the register holds is the physical register's content plus that offset. Physical tag 0 is a hard-wired zero.

The block takes one operation per cycle. Moves of a small constant, and adds, subtracts, increments and decrements by a small constant, are settled inside the map table. They only rewrite the destination's tag/offset pair, use no physical register and send nothing to execution. Any other operation is emitted downstream. It carries each source's tag and offset as separate fields and a freshly allocated destination tag taken from a FIFO free list. Released tags come back through a one-tag-per-cycle return port.

Operation codes on `in_op`: 0 move-immediate, 1 add-immediate, 2 subtract-immediate, 3 increment, 4 decrement, 5 to 7 general two-source operation. Emitted kind codes on `uop_kind`: 0 general, 1 two-input add, 2 three-input add.

Top module: `fold_renamer`

## Requirements
- R1: After reset, every architectural register reads as tag 0 with offset 0, `in_ready` is high, and non-folded operations receive tags 1, 2, 3, … in that order.
- R2: A move of an immediate no larger than 1023 emits no micro-op, consumes no tag, and leaves the destination mapped to tag 0 with the immediate as its offset.
- R3: An add-immediate or increment whose new offset (old offset plus immediate, increment counting as 1) is at most 1023 emits no micro-op, keeps the source's tag and stores the sum as the destination offset.
- R4: When such an add would exceed 1023, or its immediate exceeds 1023, a micro-op is emitted instead. The destination then maps to the new tag with offset 0.
- R5: A subtract-immediate or decrement folds only when the immediate does not exceed the source offset. Otherwise it is emitted with the two's-complement negated immediate on `uop_imm` (all ones for a decrement).
- R6: An emitted add-class operation has kind 2 (three-input add) when its source offset is nonzero and kind 1 otherwise. The source offset travels in `uop_s1_off`.
- R7: A general operation is emitted with kind 0, `in_imm` passed through, both sources as separate tag and offset fields, and a fresh destination tag with offset 0.
- R8: With the free list empty, `in_ready` is low for non-foldable operations, which are held with no micro-op, and stays high for foldable ones. A tag returned through the free port is the next one allocated.
- R9: A folded operation whose source and destination are the same register uses the old entry, and an operation in the very next cycle sees the updated entry.
- R10: The micro-op appears on the outputs in the cycle after the operation is accepted. A move with an immediate above 1023 is emitted as a kind-1 add on source tag 0 with offset 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| in_valid | input | 1 | Incoming operation is present |
| in_ready | output | 1 | Operation is accepted at this edge when valid |
| in_op | input | 3 | Operation class code |
| in_dst | input | 4 | Destination architectural register |
| in_src1 | input | 4 | First source architectural register |
| in_src2 | input | 4 | Second source architectural register |
| in_imm | input | 16 | Immediate operand |
| free_valid | input | 1 | A released tag is being returned |
| free_tag | input | 6 | Returned tag (never 0) |
| uop_valid | output | 1 | Emitted micro-op present |
| uop_kind | output | 2 | Emitted kind: 0 general, 1 add, 2 three-input add |
| uop_dst | output | 6 | Allocated destination tag |
| uop_s1_tag | output | 6 | First source tag |
| uop_s1_off | output | 10 | First source offset |
| uop_s2_tag | output | 6 | Second source tag |
| uop_s2_off | output | 10 | Second source offset |
| uop_imm | output | 16 | Immediate for the emitted operation |

## Verification
Two things can happen in the same cycle: a tag coming back on the return port and a non-folded operation taking the head of the free list. The bench first drains the list to one entry. It then returns one tag in the very cycle an operation pops the last one. It judges the result by requiring the popped tag on the first micro-op and the returned tag on the next one, with `in_ready` held high in between. A second overlap is also provoked: a same-register fold is followed at once by a consumer, and that consumer's source offset must already include the fold.

// File: rtl/fold_pkg.sv
package fold_pkg;
  typedef enum logic [2:0] {
    OP_MOVI = 3'd0,
    OP_ADDI = 3'd1,
    OP_SUBI = 3'd2,
    OP_INC  = 3'd3,
    OP_DEC  = 3'd4,
    OP_GEN  = 3'd5
  } op_e;

  typedef enum logic [1:0] {
    UK_GEN  = 2'd0,
    UK_ADD2 = 2'd1,
    UK_ADD3 = 2'd2
  } ukind_e;
endpackage

// File: rtl/fold_map_table.sv
module fold_map_table #(
  parameter int AREGS = 16,
  parameter int TAG_W = 6,
  parameter int OFF_W = 10,
  localparam int AW = $clog2(AREGS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [AW-1:0]    wr_addr,
  input  logic [TAG_W-1:0] wr_tag,
  input  logic [OFF_W-1:0] wr_off,
  input  logic [AW-1:0]    ra_addr,
  output logic [TAG_W-1:0] ra_tag,
  output logic [OFF_W-1:0] ra_off,
  input  logic [AW-1:0]    rb_addr,
  output logic [TAG_W-1:0] rb_tag,
  output logic [OFF_W-1:0] rb_off
);
  logic [TAG_W-1:0] tag_q [AREGS];
  logic [OFF_W-1:0] off_q [AREGS];

  // reads see the entry as it stood before this edge's write
  assign ra_tag = tag_q[ra_addr];
  assign ra_off = off_q[ra_addr];
  assign rb_tag = tag_q[rb_addr];
  assign rb_off = off_q[rb_addr];

  for (genvar g = 0; g < AREGS; g++) begin : g_ent
    logic ent_we;
    assign ent_we = wr_en && (wr_addr == AW'(g));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        tag_q[g] <= '0;
        off_q[g] <= '0;
      end else if (ent_we) begin
        tag_q[g] <= wr_tag;
        off_q[g] <= wr_off;
      end
    end
  end
endmodule

// File: rtl/fold_free_list.sv
module fold_free_list #(
  parameter int NTAGS = 64,
  localparam int TAG_W = $clog2(NTAGS),
  localparam int CNT_W = $clog2(NTAGS + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             pop,
  output logic [TAG_W-1:0] head,
  output logic             empty,
  input  logic             push,
  input  logic [TAG_W-1:0] push_tag
);
  logic [TAG_W-1:0] slot_q [NTAGS];
  logic [TAG_W-1:0] rd_q, rd_d, wr_q, wr_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;

  assign head  = slot_q[rd_q];
  assign empty = (cnt_q == '0);

  always_comb begin
    rd_d  = rd_q;
    wr_d  = wr_q;
    cnt_d = cnt_q;
    if (pop) rd_d = rd_q + 1'b1;
    if (push) wr_d = wr_q + 1'b1;
    if (push && !pop) cnt_d = cnt_q + 1'b1;
    if (pop && !push) cnt_d = cnt_q - 1'b1;
  end

  // tag 0 is the zero register, so reset holds 1..NTAGS-1
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_q  <= '0;
      wr_q  <= TAG_W'(NTAGS - 1);
      cnt_q <= CNT_W'(NTAGS - 1);
    end else begin
      rd_q  <= rd_d;
      wr_q  <= wr_d;
      cnt_q <= cnt_d;
    end
  end

  for (genvar g = 0; g < NTAGS; g++) begin : g_slot
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) slot_q[g] <= TAG_W'(g + 1);
      else if (push && (wr_q == TAG_W'(g))) slot_q[g] <= push_tag;
    end
  end

  assert_no_pop_empty_R8: assert property (@(posedge clk) disable iff (!rst_n)
    pop |-> cnt_q != '0);
  assert_no_push_full_R8: assert property (@(posedge clk) disable iff (!rst_n)
    push |-> (cnt_q != CNT_W'(NTAGS)) && (push_tag != '0));
endmodule

// File: rtl/fold_offset_alu.sv
module fold_offset_alu
  import fold_pkg::*;
#(
  parameter int OFF_W = 10,
  parameter int IMM_W = 16
) (
  input  logic [2:0]       op,
  input  logic [OFF_W-1:0] src_off,
  input  logic [IMM_W-1:0] imm,
  output logic             add_class,
  output logic             no_src,
  output logic             can_fold,
  output logic [OFF_W-1:0] new_off,
  output logic [IMM_W-1:0] emit_imm
);
  localparam logic [IMM_W:0] MAXOFF = (IMM_W + 1)'((1 << OFF_W) - 1);

  logic [IMM_W:0] mag, off_x, sum, dif;

  assign off_x = (IMM_W + 1)'(src_off);
  assign sum   = off_x + mag;
  assign dif   = off_x - mag;

  always_comb begin
    mag       = {1'b0, imm};
    add_class = 1'b1;
    no_src    = 1'b0;
    can_fold  = 1'b0;
    new_off   = '0;
    emit_imm  = imm;
    case (op_e'(op))
      OP_MOVI: begin
        no_src   = 1'b1;
        can_fold = (mag <= MAXOFF);
        new_off  = mag[OFF_W-1:0];
      end
      OP_ADDI, OP_INC: begin
        if (op_e'(op) == OP_INC) mag = (IMM_W + 1)'(1);
        can_fold = (sum <= MAXOFF);
        new_off  = sum[OFF_W-1:0];
        emit_imm = mag[IMM_W-1:0];
      end
      OP_SUBI, OP_DEC: begin
        if (op_e'(op) == OP_DEC) mag = (IMM_W + 1)'(1);
        can_fold = (mag <= off_x);
        new_off  = dif[OFF_W-1:0];
        emit_imm = IMM_W'(-mag);
      end
      default: add_class = 1'b0;
    endcase
  end

  always_comb begin
    if (can_fold) assert_fold_fits_R3: assert (add_class);
  end
endmodule

// File: rtl/fold_renamer.sv
module fold_renamer
  import fold_pkg::*;
#(
  parameter int AREGS = 16,
  parameter int NTAGS = 64,
  parameter int OFF_W = 10,
  parameter int IMM_W = 16,
  localparam int AW    = $clog2(AREGS),
  localparam int TAG_W = $clog2(NTAGS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic [2:0]       in_op,
  input  logic [AW-1:0]    in_dst,
  input  logic [AW-1:0]    in_src1,
  input  logic [AW-1:0]    in_src2,
  input  logic [IMM_W-1:0] in_imm,
  input  logic             free_valid,
  input  logic [TAG_W-1:0] free_tag,
  output logic             uop_valid,
  output logic [1:0]       uop_kind,
  output logic [TAG_W-1:0] uop_dst,
  output logic [TAG_W-1:0] uop_s1_tag,
  output logic [OFF_W-1:0] uop_s1_off,
  output logic [TAG_W-1:0] uop_s2_tag,
  output logic [OFF_W-1:0] uop_s2_off,
  output logic [IMM_W-1:0] uop_imm
);
  // reset: asynchronous assertion, synchronous release
  logic [1:0] rsync_q;
  logic       rst_i_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rsync_q <= '0;
    else        rsync_q <= {rsync_q[0], 1'b1};
  end
  assign rst_i_n = rsync_q[1];

  logic [TAG_W-1:0] ma_tag, mb_tag, s1_tag, fl_head, wr_tag;
  logic [OFF_W-1:0] ma_off, mb_off, s1_off, new_off, wr_off;
  logic [IMM_W-1:0] emit_imm;
  logic add_class, no_src, can_fold, fl_empty, accept, alloc;

  fold_offset_alu #(.OFF_W(OFF_W), .IMM_W(IMM_W)) i_alu (
    .op(in_op), .src_off(ma_off), .imm(in_imm),
    .add_class(add_class), .no_src(no_src), .can_fold(can_fold),
    .new_off(new_off), .emit_imm(emit_imm)
  );

  assign s1_tag   = no_src ? '0 : ma_tag;
  assign s1_off   = no_src ? '0 : ma_off;
  assign in_ready = can_fold || !fl_empty;
  assign accept   = in_valid && in_ready;
  assign alloc    = accept && !can_fold;
  assign wr_tag   = can_fold ? s1_tag : fl_head;
  assign wr_off   = can_fold ? new_off : '0;

  fold_map_table #(.AREGS(AREGS), .TAG_W(TAG_W), .OFF_W(OFF_W)) i_map (
    .clk(clk), .rst_n(rst_i_n),
    .wr_en(accept), .wr_addr(in_dst), .wr_tag(wr_tag), .wr_off(wr_off),
    .ra_addr(in_src1), .ra_tag(ma_tag), .ra_off(ma_off),
    .rb_addr(in_src2), .rb_tag(mb_tag), .rb_off(mb_off)
  );

  fold_free_list #(.NTAGS(NTAGS)) i_free (
    .clk(clk), .rst_n(rst_i_n),
    .pop(alloc), .head(fl_head), .empty(fl_empty),
    .push(free_valid), .push_tag(free_tag)
  );

  // next-state for the emitted micro-op
  logic [1:0]       kind_d;
  logic [TAG_W-1:0] s2_tag_d;
  logic [OFF_W-1:0] s2_off_d;
  logic [IMM_W-1:0] imm_d;
  always_comb begin
    if (add_class) begin
      kind_d   = (s1_off != '0) ? UK_ADD3 : UK_ADD2;
      s2_tag_d = '0;
      s2_off_d = '0;
      imm_d    = emit_imm;
    end else begin
      kind_d   = UK_GEN;
      s2_tag_d = mb_tag;
      s2_off_d = mb_off;
      imm_d    = in_imm;
    end
  end

  always_ff @(posedge clk or negedge rst_i_n) begin
    if (!rst_i_n) uop_valid <= 1'b0;
    else          uop_valid <= alloc;
  end

  always_ff @(posedge clk or negedge rst_i_n) begin
    if (!rst_i_n) begin
      uop_kind   <= '0;
      uop_dst    <= '0;
      uop_s1_tag <= '0;
      uop_s1_off <= '0;
      uop_s2_tag <= '0;
      uop_s2_off <= '0;
      uop_imm    <= '0;
    end else if (alloc) begin
      uop_kind   <= kind_d;
      uop_dst    <= fl_head;
      uop_s1_tag <= s1_tag;
      uop_s1_off <= s1_off;
      uop_s2_tag <= s2_tag_d;
      uop_s2_off <= s2_off_d;
      uop_imm    <= imm_d;
    end
  end

  assert_stall_no_uop_R8: assert property (@(posedge clk) disable iff (!rst_i_n)
    (in_valid && !in_ready) |=> !uop_valid);
  assert_fold_no_uop_R2: assert property (@(posedge clk) disable iff (!rst_i_n)
    (accept && can_fold) |=> !uop_valid);
  assert_alloc_next_cycle_R10: assert property (@(posedge clk) disable iff (!rst_i_n)
    alloc |=> uop_valid && (uop_dst == $past(fl_head)));
  assert_fresh_tag_nonzero_R7: assert property (@(posedge clk) disable iff (!rst_i_n)
    uop_valid |-> uop_dst != '0);
  assert_add3_has_offset_R6: assert property (@(posedge clk) disable iff (!rst_i_n)
    (uop_valid && uop_kind == UK_ADD3) |-> uop_s1_off != '0);
endmodule

// File: tb/test_fold_renamer.sv
module test_fold_renamer;
  import fold_pkg::*;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #4 clk = ~clk;  // 125 MHz

  logic        in_valid = 1'b0, in_ready, free_valid = 1'b0;
  logic [2:0]  in_op = '0;
  logic [3:0]  in_dst = '0, in_src1 = '0, in_src2 = '0;
  logic [15:0] in_imm = '0;
  logic [5:0]  free_tag = '0;
  logic        uop_valid;
  logic [1:0]  uop_kind;
  logic [5:0]  uop_dst, uop_s1_tag, uop_s2_tag;
  logic [9:0]  uop_s1_off, uop_s2_off;
  logic [15:0] uop_imm;

  fold_renamer i_fold_renamer (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_op(in_op), .in_dst(in_dst), .in_src1(in_src1), .in_src2(in_src2),
    .in_imm(in_imm), .free_valid(free_valid), .free_tag(free_tag),
    .uop_valid(uop_valid), .uop_kind(uop_kind), .uop_dst(uop_dst),
    .uop_s1_tag(uop_s1_tag), .uop_s1_off(uop_s1_off),
    .uop_s2_tag(uop_s2_tag), .uop_s2_off(uop_s2_off), .uop_imm(uop_imm)
  );

  int checks = 0, fails = 0;

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  typedef struct packed {
    logic [2:0]  op;
    logic [3:0]  dst, s1, s2;
    logic [15:0] imm;
    logic        ev;
    logic [1:0]  ek;
    logic [5:0]  edst, es1t;
    logic [9:0]  es1o;
    logic [5:0]  es2t;
    logic [9:0]  es2o;
    logic [15:0] eimm;
  } vec_t;

  localparam int NV = 20;
  localparam vec_t VECS [NV] = '{
    '{3'd5, 4'd1, 4'd2, 4'd3, 16'd0,    1'b1, 2'd0, 6'd1,  6'd0, 10'd0,    6'd0,  10'd0, 16'd0},      // R1 R7
    '{3'd0, 4'd2, 4'd0, 4'd0, 16'd5,    1'b0, 2'd0, 6'd0,  6'd0, 10'd0,    6'd0,  10'd0, 16'd0},      // R2
    '{3'd5, 4'd4, 4'd2, 4'd1, 16'd0,    1'b1, 2'd0, 6'd2,  6'd0, 10'd5,    6'd1,  10'd0, 16'd0},      // R2 R7
    '{3'd1, 4'd2, 4'd2, 4'd0, 16'd1000, 1'b0, 2'd0, 6'd0,  6'd0, 10'd0,    6'd0,  10'd0, 16'd0},      // R3 R9
    '{3'd3, 4'd2, 4'd2, 4'd0, 16'd0,    1'b0, 2'd0, 6'd0,  6'd0, 10'd0,    6'd0,  10'd0, 16'd0},      // R3 R9
    '{3'd5, 4'd5, 4'd2, 4'd2, 16'd0,    1'b1, 2'd0, 6'd3,  6'd0, 10'd1006, 6'd0,  10'd1006, 16'd0},   // R3 R9
    '{3'd1, 4'd6, 4'd2, 4'd0, 16'd18,   1'b1, 2'd2, 6'd4,  6'd0, 10'd1006, 6'd0,  10'd0, 16'd18},     // R4 R6
    '{3'd1, 4'd7, 4'd6, 4'd0, 16'd1023, 1'b0, 2'd0, 6'd0,  6'd0, 10'd0,    6'd0,  10'd0, 16'd0},      // R3
    '{3'd3, 4'd7, 4'd7, 4'd0, 16'd0,    1'b1, 2'd2, 6'd5,  6'd4, 10'd1023, 6'd0,  10'd0, 16'd1},      // R4 R6
    '{3'd5, 4'd8, 4'd7, 4'd6, 16'd0,    1'b1, 2'd0, 6'd6,  6'd5, 10'd0,    6'd4,  10'd0, 16'd0},      // R4
    '{3'd4, 4'd8, 4'd8, 4'd0, 16'd0,    1'b1, 2'd1, 6'd7,  6'd6, 10'd0,    6'd0,  10'd0, 16'hFFFF},   // R5 R6
    '{3'd0, 4'd9, 4'd0, 4'd0, 16'd40,   1'b0, 2'd0, 6'd0,  6'd0, 10'd0,    6'd0,  10'd0, 16'd0},      // R2
    '{3'd2, 4'd9, 4'd9, 4'd0, 16'd41,   1'b1, 2'd2, 6'd8,  6'd0, 10'd40,   6'd0,  10'd0, 16'hFFD7},   // R5 R6
    '{3'd2, 4'd10,4'd2, 4'd0, 16'd6,    1'b0, 2'd0, 6'd0,  6'd0, 10'd0,    6'd0,  10'd0, 16'd0},      // R5
    '{3'd4, 4'd10,4'd10,4'd0, 16'd0,    1'b0, 2'd0, 6'd0,  6'd0, 10'd0,    6'd0,  10'd0, 16'd0},      // R5 R9
    '{3'd5, 4'd11,4'd10,4'd9, 16'd0,    1'b1, 2'd0, 6'd9,  6'd0, 10'd999,  6'd8,  10'd0, 16'd0},      // R5 R9
    '{3'd0, 4'd12,4'd0, 4'd0, 16'd2000, 1'b1, 2'd1, 6'd10, 6'd0, 10'd0,    6'd0,  10'd0, 16'd2000},   // R10
    '{3'd0, 4'd13,4'd0, 4'd0, 16'd1023, 1'b0, 2'd0, 6'd0,  6'd0, 10'd0,    6'd0,  10'd0, 16'd0},      // R2
    '{3'd5, 4'd14,4'd13,4'd12,16'd0,    1'b1, 2'd0, 6'd11, 6'd0, 10'd1023, 6'd10, 10'd0, 16'd0},      // R2 R7
    '{3'd1, 4'd15,4'd15,4'd0, 16'd1500, 1'b1, 2'd1, 6'd12, 6'd0, 10'd0,    6'd0,  10'd0, 16'd1500}    // R4
  };

  // called at a falling edge; returns at the falling edge after acceptance
  task automatic drive(input logic [2:0] op, input logic [3:0] d, input logic [3:0] a,
                       input logic [3:0] b, input logic [15:0] imm);
    in_valid = 1'b1; in_op = op; in_dst = d; in_src1 = a; in_src2 = b; in_imm = imm;
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic run_vec(input vec_t v, input int idx);
    logic [65:0] act, exp;
    drive(v.op, v.dst, v.s1, v.s2, v.imm);
    if (v.ev) begin
      act = {uop_valid, uop_kind, uop_dst, uop_s1_tag, uop_s1_off, uop_s2_tag, uop_s2_off, uop_imm};
      exp = {1'b1, v.ek, v.edst, v.es1t, v.es1o, v.es2t, v.es2o, v.eimm};
      chk(act == exp, $sformatf("vector %0d (R3..R10 table)", idx), act[63:0], exp[63:0]);
    end else begin
      chk(uop_valid == 1'b0, $sformatf("vector %0d fold no uop (R2 R3 R5)", idx), 64'(uop_valid), 64'd0);
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    // R1: reset state
    chk(in_ready == 1'b1 && uop_valid == 1'b0, "R1 reset ready/valid", {in_ready, uop_valid}, 2'b10);

    for (int i = 0; i < NV; i++) run_vec(VECS[i], i);

    // R8: drain the free list (tags 13..63 remain)
    for (int k = 0; k < 51; k++) begin
      drive(3'd5, 4'd1, 4'd3, 4'd3, 16'd0);
      chk(uop_valid && uop_dst == 6'(13 + k), "R1 R8 allocation order", {uop_valid, uop_dst}, {1'b1, 6'(13 + k)});
    end
    in_op = 3'd5; in_dst = 4'd15; in_src1 = 4'd3; in_src2 = 4'd3; in_imm = '0;
    #1 chk(in_ready == 1'b0, "R8 empty list not ready for general op", 64'(in_ready), 64'd0);
    in_op = 3'd0; in_dst = 4'd3; in_imm = 16'd7;
    #1 chk(in_ready == 1'b1, "R8 empty list still ready for fold", 64'(in_ready), 64'd1);
    @(posedge clk); @(negedge clk);
    chk(uop_valid == 1'b0, "R8 R2 fold with empty list", 64'(uop_valid), 64'd0);
    in_op = 3'd5; in_dst = 4'd15; in_src1 = 4'd3; in_src2 = 4'd3; in_imm = '0;
    for (int k = 0; k < 3; k++) begin
      @(posedge clk); @(negedge clk);
      chk(uop_valid == 1'b0 && in_ready == 1'b0, "R8 held while empty", {uop_valid, in_ready}, 2'b00);
    end
    free_valid = 1'b1; free_tag = 6'd33;
    @(posedge clk); @(negedge clk);
    free_valid = 1'b0;
    chk(uop_valid == 1'b0 && in_ready == 1'b1, "R8 ready after return", {uop_valid, in_ready}, 2'b01);
    @(posedge clk); @(negedge clk);
    chk(uop_valid && uop_dst == 6'd33 && uop_s1_tag == 6'd0 && uop_s1_off == 10'd7,
        "R8 R2 returned tag used", {uop_valid, uop_dst, uop_s1_tag, uop_s1_off}, {1'b1, 6'd33, 6'd0, 10'd7});
    in_valid = 1'b0;

    // same-cycle return and allocation
    free_valid = 1'b1; free_tag = 6'd40;
    @(posedge clk); @(negedge clk);
    free_tag = 6'd41;
    drive(3'd5, 4'd4, 4'd0, 4'd0, 16'd0);
    free_valid = 1'b0;
    chk(uop_valid && uop_dst == 6'd40, "R8 pop with push", {uop_valid, uop_dst}, {1'b1, 6'd40});
    chk(in_ready == 1'b1, "R8 push kept list non-empty", 64'(in_ready), 64'd1);
    drive(3'd5, 4'd5, 4'd0, 4'd0, 16'd0);
    chk(uop_valid && uop_dst == 6'd41, "R8 pushed tag next", {uop_valid, uop_dst}, {1'b1, 6'd41});
    in_valid = 1'b0;

    // R1: reset again mid-run
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk(uop_valid == 1'b0 && in_ready == 1'b1, "R1 second reset", {uop_valid, in_ready}, 2'b01);
    drive(3'd5, 4'd7, 4'd2, 4'd9, 16'd0);
    chk({uop_valid, uop_dst, uop_s1_tag, uop_s1_off, uop_s2_tag, uop_s2_off} == {1'b1, 6'd1, 6'd0, 10'd0, 6'd0, 10'd0},
        "R1 map and free list restored", {uop_valid, uop_dst, uop_s1_tag, uop_s1_off, uop_s2_tag, uop_s2_off},
        {1'b1, 6'd1, 6'd0, 10'd0, 6'd0, 10'd0});
    in_valid = 1'b0;
    @(negedge clk);
    chk(uop_valid == 1'b0, "R10 valid lasts one cycle", 64'(uop_valid), 64'd0);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule